// File: doc/BRIEF.md
# I/O Port Decoder with Control Latches

This block sits on the I/O side of an 8-bit CPU bus that has separate I/O requests. It decodes the low address byte during I/O cycles and produces two chip-enable strobes: one for a parallel I/O chip and one for a four-channel counter/timer chip. For the timer it also passes on the channel index taken from the two lowest address bits. Decoding is partial. A shared group condition on the upper address nibble is widened per device by the lower nibble, so each chip answers on a block of four port addresses.

The block also holds two write-only 8-bit control latches, and each one is fully decoded at a single port. The video-control latch at port 0x84 carries bits for display image, pixel/colour access, CPU image, high-colour mode and RAM8 block. The bank-control latch at port 0x86 carries bits for RAM4 enable, RAM4 write enable and upper system-ROM bank. Some of these bits steer the memory map. When a write changes any of them, the block raises a one-clock event so that the memory mapper can rebuild its page table.

Interrupt-acknowledge cycles, where M1 and IORQ are both asserted, never select a device and never write a latch.

Top module: `io_port_decoder`

## Requirements
- R1: An enable or latch write needs all four of these: iorq_i=1, m1_i=0, addr_i[7]=1 and addr_i[6:4]=3'b000. If any of them fails, both enables stay 0.
- R2: pio_ce_o is 1, combinationally, when the group condition holds and addr_i[3:2]=2'b10, which is ports 0x88 to 0x8B.
- R3: ctc_ce_o is 1 when the group condition holds and addr_i[3:2]=2'b11, which is ports 0x8C to 0x8F. While it is 1, ctc_chan_o equals addr_i[1:0]; otherwise ctc_chan_o is 0.
- R4: A cycle with m1_i=1 and iorq_i=1 asserts neither enable and changes neither latch, whatever the address.
- R5: vid_latch_o resets to 0x00. It loads data_i on the rising edge where wr_i=1 and the address is exactly 0x84 under the group condition.
- R6: bank_latch_o resets to 0x00. It loads data_i on the rising edge where wr_i=1 and the address is exactly 0x86 under the group condition.
- R7: A latch keeps its value on any other cycle. This covers read cycles, and writes to aliases that differ in addr_i[3:0] (for example 0x85) or in addr_i[7:4] (for example 0x94).
- R8: map_change_o is 1 for the clock cycle that follows a latch write in which the written value differs from the old one in a memory-mapping bit. The mapping bits are vid bits 1, 2 and 4 (mask 0x16) and bank bits 0, 1 and 7 (mask 0x83).
- R9: A latch write that alters only non-mapping bits, or that rewrites the same value, leaves map_change_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iorq_i | input | 1 | I/O request, active high |
| m1_i | input | 1 | Opcode fetch / interrupt acknowledge marker, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| addr_i | input | 8 | Low address byte |
| data_i | input | 8 | Write data |
| pio_ce_o | output | 1 | Parallel I/O chip enable |
| ctc_ce_o | output | 1 | Counter/timer chip enable |
| ctc_chan_o | output | 2 | Timer channel index |
| vid_latch_o | output | 8 | Video-control latch contents |
| bank_latch_o | output | 8 | Bank-control latch contents |
| map_change_o | output | 1 | One-clock memory-map change event |

## Verification
The assertions check on every cycle that the two enables never overlap and never fire without a plain I/O request. They also check that an interrupt acknowledge selects nothing, that a latch loads exactly the data presented with its write, that it holds otherwise, and that a change event always follows a write. Only the bench scenarios can show that the partial-decode aliases land on the right ports. The same holds for full decoding, which rejects 0x85 and 0x94. The bench scenarios also show that the event fires for the mapping bits and stays quiet when only display bits change or a value is rewritten.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned NUM_LATCH = 2;

  // group condition on addr[7:4]
  localparam logic [3:0] GROUP_HI = 4'h8;
  // per-device extension on addr[3:2]
  localparam logic [1:0] PIO_SEL  = 2'b10;
  localparam logic [1:0] CTC_SEL  = 2'b11;
  // full decode on addr[3:0]
  localparam logic [3:0] VID_LO   = 4'h4;
  localparam logic [3:0] BANK_LO  = 4'h6;

  localparam logic [DW-1:0] VID_MAP_MASK  = 8'h16;
  localparam logic [DW-1:0] BANK_MAP_MASK = 8'h83;
  localparam logic [DW-1:0] LATCH_RESET   = 8'h00;

  typedef struct packed {
    logic grp;
    logic pio;
    logic ctc;
    logic vid;
    logic bank;
  } io_sel_t;
endpackage

// File: rtl/iodec_match.sv
module iodec_match
  import iodec_pkg::*;
(
  input  logic          iorq_i,
  input  logic          m1_i,
  input  logic [AW-1:0] addr_i,
  output io_sel_t       sel_o
);
  logic io_cyc;

  // intack (m1 with iorq) is excluded here
  assign io_cyc     = iorq_i && !m1_i;
  assign sel_o.grp  = io_cyc && (addr_i[7:4] == GROUP_HI);
  assign sel_o.pio  = sel_o.grp && (addr_i[3:2] == PIO_SEL);
  assign sel_o.ctc  = sel_o.grp && (addr_i[3:2] == CTC_SEL);
  assign sel_o.vid  = sel_o.grp && (addr_i[3:0] == VID_LO);
  assign sel_o.bank = sel_o.grp && (addr_i[3:0] == BANK_LO);
endmodule

// File: rtl/iodec_latch.sv
module iodec_latch #(
  parameter int unsigned     DW        = 8,
  parameter logic [DW-1:0]   RESET_VAL = '0,
  parameter logic [DW-1:0]   MAP_MASK  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] q_o,
  output logic          chg_o
);
  logic map_diff;

  assign map_diff = |((q_o ^ data_i) & MAP_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= RESET_VAL;
      chg_o <= 1'b0;
    end else begin
      chg_o <= we_i && map_diff;
      if (we_i) q_o <= data_i;
    end
  end

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(data_i)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  p_chg_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> $past(we_i));
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import iodec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iorq_i,
  input  logic          m1_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          pio_ce_o,
  output logic          ctc_ce_o,
  output logic [1:0]    ctc_chan_o,
  output logic [DW-1:0] vid_latch_o,
  output logic [DW-1:0] bank_latch_o,
  output logic          map_change_o
);
  localparam logic [NUM_LATCH-1:0][DW-1:0] MASKS = {BANK_MAP_MASK, VID_MAP_MASK};

  io_sel_t                      sel;
  logic [NUM_LATCH-1:0]         lat_we;
  logic [NUM_LATCH-1:0]         lat_chg;
  logic [NUM_LATCH-1:0][DW-1:0] lat_q;

  iodec_match u_match (
    .iorq_i (iorq_i),
    .m1_i   (m1_i),
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign pio_ce_o   = sel.pio;
  assign ctc_ce_o   = sel.ctc;
  assign ctc_chan_o = sel.ctc ? addr_i[1:0] : 2'b00;

  // a write strobe with rd also high is still treated as a write
  assign lat_we = {sel.bank, sel.vid} & {NUM_LATCH{wr_i}};

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
    iodec_latch #(
      .DW        (DW),
      .RESET_VAL (LATCH_RESET),
      .MAP_MASK  (MASKS[g])
    ) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (lat_we[g]),
      .data_i (data_i),
      .q_o    (lat_q[g]),
      .chg_o  (lat_chg[g])
    );
  end

  assign vid_latch_o  = lat_q[0];
  assign bank_latch_o = lat_q[1];
  assign map_change_o = |lat_chg;

  logic unused_rd;
  assign unused_rd = rd_i;

  p_group_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pio_ce_o || ctc_ce_o) |-> (iorq_i && !m1_i && addr_i[7] && (addr_i[6:4] == 3'b000)));
  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pio_ce_o, ctc_ce_o}));
  p_chan_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctc_ce_o |-> (ctc_chan_o == 2'b00));
  p_inta_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iorq_i && m1_i) |=> ($stable(vid_latch_o) && $stable(bank_latch_o) && !map_change_o));
  p_inta_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iorq_i && m1_i) |-> (!pio_ce_o && !ctc_ce_o));
  p_event_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_change_o |-> $past(wr_i && iorq_i && !m1_i));
endmodule

// File: tb/io_port_decoder_test.sv
`timescale 1ns/1ps
module io_port_decoder_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       iorq = 1'b0, m1 = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] addr = 8'h00, data = 8'h00;
  logic       pio_ce, ctc_ce, map_chg;
  logic [1:0] chan;
  logic [7:0] vid, bank;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  io_port_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .iorq_i(iorq), .m1_i(m1), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .data_i(data), .pio_ce_o(pio_ce), .ctc_ce_o(ctc_ce),
    .ctc_chan_o(chan), .vid_latch_o(vid), .bank_latch_o(bank), .map_change_o(map_chg)
  );

  // {iorq, m1, addr, exp_pio, exp_ctc, exp_chan}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h88, 1'b1, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'h8B, 1'b1, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'h8C, 1'b0, 1'b1, 2'd0},
    {1'b1, 1'b0, 8'h8D, 1'b0, 1'b1, 2'd1},
    {1'b1, 1'b0, 8'h8E, 1'b0, 1'b1, 2'd2},
    {1'b1, 1'b0, 8'h8F, 1'b0, 1'b1, 2'd3},
    {1'b1, 1'b1, 8'h8C, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b1, 8'h88, 1'b0, 1'b0, 2'd0},
    {1'b0, 1'b0, 8'h88, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'hC8, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'h98, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'h84, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'h08, 1'b0, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; samples latches and event in the cycle after the edge
  task automatic bus_cyc(input logic m1v, input logic rdv, input logic wrv,
                         input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    iorq = 1'b1; m1 = m1v; rd = rdv; wr = wrv; addr = a; data = d;
    @(negedge clk);
    iorq = 1'b0; m1 = 1'b0; rd = 1'b0; wr = 1'b0; addr = 8'h00; data = 8'h00;
  endtask

  task automatic idle_pulse(input string req);
    @(negedge clk);
    chk(req, {7'd0, map_chg}, 8'h00);
  endtask

  initial begin
    #(5.0 * 50000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset vid", vid, 8'h00);
    chk("R6 reset bank", bank, 8'h00);
    chk("R8 reset event", {7'd0, map_chg}, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      iorq = VEC[i][13]; m1 = VEC[i][12]; addr = VEC[i][11:4];
      #1;
      chk($sformatf("vec %0d R1 R2 pio", i), {7'd0, pio_ce}, {7'd0, VEC[i][3]});
      chk($sformatf("vec %0d R3 R4 ctc", i), {7'd0, ctc_ce}, {7'd0, VEC[i][2]});
      chk($sformatf("vec %0d R3 chan", i), {6'd0, chan}, {6'd0, VEC[i][1:0]});
    end
    @(negedge clk); iorq = 1'b0; m1 = 1'b0; addr = 8'h00;

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h84, 8'h02);
    chk("R5 vid load", vid, 8'h02);
    chk("R8 event on map bit", {7'd0, map_chg}, 8'h01);
    idle_pulse("R8 event one clock");

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h84, 8'h0B);
    chk("R5 vid load 2", vid, 8'h0B);
    chk("R9 non-map bits", {7'd0, map_chg}, 8'h00);

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h84, 8'h0B);
    chk("R9 rewrite same", {7'd0, map_chg}, 8'h00);

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h86, 8'h80);
    chk("R6 bank load", bank, 8'h80);
    chk("R8 bank bit7 event", {7'd0, map_chg}, 8'h01);
    chk("R6 vid untouched", vid, 8'h0B);
    idle_pulse("R8 bank event one clock");

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h86, 8'hFC);
    chk("R6 bank load 2", bank, 8'hFC);
    chk("R9 bank non-map", {7'd0, map_chg}, 8'h00);

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h85, 8'hFF);
    chk("R7 alias 85 vid", vid, 8'h0B);
    chk("R7 alias 85 bank", bank, 8'hFC);
    chk("R7 alias 85 event", {7'd0, map_chg}, 8'h00);

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h94, 8'h10);
    chk("R7 alias 94 vid", vid, 8'h0B);

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h96, 8'h00);
    chk("R7 alias 96 bank", bank, 8'hFC);

    bus_cyc(1'b1, 1'b0, 1'b1, 8'h84, 8'h10);
    chk("R4 intack vid", vid, 8'h0B);
    chk("R4 intack event", {7'd0, map_chg}, 8'h00);

    bus_cyc(1'b0, 1'b1, 1'b0, 8'h86, 8'h00);
    chk("R7 read cycle bank", bank, 8'hFC);

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h84, 8'h10);
    chk("R5 vid ram8", vid, 8'h10);
    chk("R8 ram8 event", {7'd0, map_chg}, 8'h01);

    bus_cyc(1'b0, 1'b0, 1'b1, 8'h86, 8'hFD);
    chk("R8 ram4 event", {7'd0, map_chg}, 8'h01);

    @(negedge clk); rst_ni = 1'b0; #1;
    chk("R5 async reset vid", vid, 8'h00);
    chk("R6 async reset bank", bank, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule